// File: doc/BRIEF.md
# Branch history ring recorder

This block keeps a rolling record of taken branches for performance analysis. The core reports each taken branch in one cycle. The report carries the address of the branch instruction, its target address and a type vector. The block decides whether the branch is recorded. That decision uses a class filter chosen by a 2-bit mode field, a monitor enable, privilege-based freeze rules and an extra disable that applies only in the newer-architecture mode. A recorded branch is written into a circular store of 64-bit entries at a write offset that wraps.

Branches whose target comes from a register write a second entry right after the first one. That entry holds the target address with bit 1 set, so a reader can tell target entries from instruction-address entries. Both entries are written in the same cycle. Software reads any entry through a combinational index port. The current write offset is also an output, so software can find the newest entry.

Top module: `br_hist_ring`

## Requirements
- R1: After reset the write offset is 0, every entry reads 0, and the class filter records nothing until the control inputs are loaded with `ctrl_upd_i`. A later reset clears entries that were written.
- R2: The type vector uses bit 0 for call, bit 1 for indirect, bit 2 for conditional, bit 3 for other and bit 4 for register-target. Mode 0 accepts all types. Mode 1 accepts only calls, mode 2 only indirect branches and mode 3 only conditional branches. A branch is recorded only when its type ANDed with the accepted mask is nonzero, so type 0 is never recorded.
- R3: Loading the controls with `mon_en_i` low makes the filter record nothing, whatever the mode field holds.
- R4: A control load takes effect for events from the next cycle on. An event in the same cycle as the load uses the previous filter.
- R5: Freeze rules, using frz_sel_i (S), frz_prob_i (P), hyp_i (H) and prob_i (Q):
  - S=1 and P=1: recording is blocked when H=1 and Q=1.
  - S=1 and P=0: recording is blocked when H=0 and Q=1.
  - S=0: recording is blocked when P=1 and Q=1.
- R6: When `new_arch_i` is 1, recording is also blocked when `rec_dis_i` is 1 or when `prob_i` is 0.
- R7: A recorded branch writes its instruction address at the current offset. The offset then advances by one, modulo the entry count.
- R8: A recorded branch with type bit 4 set also writes its target address, with bit 1 forced to 1, at the next position modulo the entry count. The offset then ends two positions further on. This second write also wraps from the last entry to entry 0.
- R9: `rd_data_o` returns the entry selected by `rd_idx_i` in the same cycle, and `wr_ofs_o` shows the offset that the next recorded branch will use.
- R10: The entry count is 2^ENTRIES_LOG2, with the exponent clamped to the range 1 to 5. A setting of 7 therefore yields 32 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_upd_i | input | 1 | Load the filter from mon_en_i and filt_mode_i |
| mon_en_i | input | 1 | Monitor alert enable; 0 selects record-nothing |
| filt_mode_i | input | 2 | Class filter mode |
| frz_sel_i | input | 1 | Freeze rule select |
| frz_prob_i | input | 1 | Freeze in problem state |
| hyp_i | input | 1 | Hypervisor state |
| prob_i | input | 1 | Problem (user) state |
| new_arch_i | input | 1 | Newer-architecture mode |
| rec_dis_i | input | 1 | Recording disable (newer mode only) |
| ev_valid_i | input | 1 | Taken-branch event |
| ev_pc_i | input | ADDR_W | Branch instruction address |
| ev_tgt_i | input | ADDR_W | Branch target address |
| ev_type_i | input | 5 | Branch type vector |
| rd_idx_i | input | IDX_W | Read index |
| rd_data_o | output | ADDR_W | Entry at rd_idx_i |
| wr_ofs_o | output | IDX_W | Current write offset |

## Verification
A wrong offset register shows up as a `wr_ofs_o` that differs from the offset the bench has counted. This appears one cycle after the event that caused it. The newest entry then also lands at an index where the bench expects something else. A stale or miscoded filter mask or freeze decision never shows as a bad value. It shows as an entry that appears where none should, or is missing where one should be, together with an offset that moves or stays still wrongly. That difference is visible in the cycle right after the event. A dropped second write or a missing target tag shows only in the entry after the instruction address, so the bench reads back the whole store after each scenario.

// File: rtl/br_hist_pkg.sv
package br_hist_pkg;
  localparam int TYPE_W   = 5;
  localparam int T_CALL   = 0;
  localparam int T_IND    = 1;
  localparam int T_COND   = 2;
  localparam int T_OTHER  = 3;
  localparam int T_XL     = 4;
  localparam int MAX_LOG2 = 5;

  typedef enum logic [1:0] {
    MODE_ALL  = 2'd0,
    MODE_CALL = 2'd1,
    MODE_IND  = 2'd2,
    MODE_COND = 2'd3
  } filt_mode_e;

  function automatic int clamp_log2(input int l);
    if (l > MAX_LOG2) return MAX_LOG2;
    if (l < 1) return 1;
    return l;
  endfunction
endpackage

// File: rtl/br_hist_filter.sv
module br_hist_filter
  import br_hist_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_upd_i,
  input  logic              mon_en_i,
  input  logic [1:0]        filt_mode_i,
  output logic [TYPE_W-1:0] mask_o
);
  localparam logic [TYPE_W-1:0] MASK_ALL = '1;

  logic [TYPE_W-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = '0;
    if (mon_en_i) begin
      unique case (filt_mode_e'(filt_mode_i))
        MODE_ALL:  mask_d = MASK_ALL;
        MODE_CALL: mask_d[T_CALL] = 1'b1;
        MODE_IND:  mask_d[T_IND]  = 1'b1;
        MODE_COND: mask_d[T_COND] = 1'b1;
        default:   mask_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         mask_q <= '0;
    else if (ctrl_upd_i) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  assert_mask_shape_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($onehot0(mask_q) && (mask_q[T_OTHER] == 1'b0)) || (mask_q == MASK_ALL));

  assert_alert_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_upd_i && !mon_en_i) |=> (mask_q == '0));

  assert_mask_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_upd_i |=> $stable(mask_q));
endmodule

// File: rtl/br_hist_gate.sv
module br_hist_gate (
  input  logic frz_sel_i,
  input  logic frz_prob_i,
  input  logic hyp_i,
  input  logic prob_i,
  input  logic new_arch_i,
  input  logic rec_dis_i,
  output logic allow_o
);
  logic frozen, arch_block;

  always_comb begin
    if (frz_sel_i) begin
      if (frz_prob_i) frozen = hyp_i && prob_i;
      else            frozen = !hyp_i && prob_i;
    end else begin
      frozen = frz_prob_i && prob_i;
    end
  end

  assign arch_block = new_arch_i && (rec_dis_i || !prob_i);
  assign allow_o    = !frozen && !arch_block;
endmodule

// File: rtl/br_hist_store.sv
module br_hist_store #(
  parameter int ADDR_W = 64,
  parameter int DEPTH  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we0_i,
  input  logic [ADDR_W-1:0] d0_i,
  input  logic              we1_i,
  input  logic [ADDR_W-1:0] d1_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_data_o,
  output logic [IDX_W-1:0]  ofs_o
);
  logic [IDX_W-1:0]  ofs_q, ofs_p1, ofs_p2;
  logic [ADDR_W-1:0] ent_view [DEPTH];

  assign ofs_p1 = IDX_W'(ofs_q + IDX_W'(1));
  assign ofs_p2 = IDX_W'(ofs_q + IDX_W'(2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ofs_q <= '0;
    else if (we1_i) ofs_q <= ofs_p2;
    else if (we0_i) ofs_q <= ofs_p1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [ADDR_W-1:0] ent_q;
    logic hit0, hit1;
    assign hit0 = we0_i && (ofs_q  == IDX_W'(i));
    assign hit1 = we1_i && (ofs_p1 == IDX_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   ent_q <= '0;
      else if (hit1) ent_q <= d1_i;
      else if (hit0) ent_q <= d0_i;
    end
    assign ent_view[i] = ent_q;
  end

  assign rd_data_o = ent_view[rd_idx_i];
  assign ofs_o     = ofs_q;

  assert_second_needs_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we1_i |-> we0_i);

  assert_target_tag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we1_i |-> d1_i[1]);

  assert_single_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we0_i && !we1_i) |=> (ofs_q == IDX_W'($past(ofs_q) + IDX_W'(1))));

  assert_double_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we1_i |=> (ofs_q == IDX_W'($past(ofs_q) + IDX_W'(2))));

  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we0_i |=> $stable(ofs_q));
endmodule

// File: rtl/br_hist_ring.sv
module br_hist_ring
  import br_hist_pkg::*;
#(
  parameter int ADDR_W       = 64,
  parameter int ENTRIES_LOG2 = 5,
  localparam int EFF_LOG2    = clamp_log2(ENTRIES_LOG2),
  localparam int DEPTH       = 1 << EFF_LOG2,
  localparam int IDX_W       = EFF_LOG2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_upd_i,
  input  logic              mon_en_i,
  input  logic [1:0]        filt_mode_i,
  input  logic              frz_sel_i,
  input  logic              frz_prob_i,
  input  logic              hyp_i,
  input  logic              prob_i,
  input  logic              new_arch_i,
  input  logic              rec_dis_i,
  input  logic              ev_valid_i,
  input  logic [ADDR_W-1:0] ev_pc_i,
  input  logic [ADDR_W-1:0] ev_tgt_i,
  input  logic [TYPE_W-1:0] ev_type_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_data_o,
  output logic [IDX_W-1:0]  wr_ofs_o
);
  localparam logic [ADDR_W-1:0] TGT_TAG = ADDR_W'(2);

  logic [TYPE_W-1:0] mask;
  logic              allow, type_hit, we0, we1;
  logic [ADDR_W-1:0] tgt_word;

  br_hist_filter i_filter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_upd_i  (ctrl_upd_i),
    .mon_en_i    (mon_en_i),
    .filt_mode_i (filt_mode_i),
    .mask_o      (mask)
  );

  br_hist_gate i_gate (
    .frz_sel_i  (frz_sel_i),
    .frz_prob_i (frz_prob_i),
    .hyp_i      (hyp_i),
    .prob_i     (prob_i),
    .new_arch_i (new_arch_i),
    .rec_dis_i  (rec_dis_i),
    .allow_o    (allow)
  );

  assign type_hit = |(ev_type_i & mask);
  assign we0      = ev_valid_i && allow && type_hit;
  assign we1      = we0 && ev_type_i[T_XL];
  assign tgt_word = ev_tgt_i | TGT_TAG;

  br_hist_store #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH)
  ) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we0_i     (we0),
    .d0_i      (ev_pc_i),
    .we1_i     (we1),
    .d1_i      (tgt_word),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_data_o),
    .ofs_o     (wr_ofs_o)
  );

  assert_type_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_type_i == '0) |-> !we0);

  assert_new_arch_block_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && new_arch_i && (rec_dis_i || !prob_i)) |=> $stable(wr_ofs_o));

  assert_frozen_hv_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_sel_i && frz_prob_i && hyp_i && prob_i) |-> !we0);
endmodule

// File: tb/test_br_hist_ring.sv
module test_br_hist_ring;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_upd = 0, mon_en = 0;
  logic [1:0] mode = 0;
  logic fsel = 0, fprob = 0, hv = 0, pr = 1, narch = 0, rdis = 0;
  logic ev_valid = 0;
  logic [63:0] ev_pc = 0, ev_tgt = 0;
  logic [4:0] ev_type = 0;
  logic [4:0] rd_idx = 0;
  logic [63:0] rd_data, rd_data_c;
  logic [4:0] wr_ofs, wr_ofs_c;

  int checks = 0, failures = 0;
  logic [63:0] exp_mem [N];
  int exp_ofs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  br_hist_ring i_br_hist_ring (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_upd_i(ctrl_upd), .mon_en_i(mon_en),
    .filt_mode_i(mode), .frz_sel_i(fsel), .frz_prob_i(fprob), .hyp_i(hv),
    .prob_i(pr), .new_arch_i(narch), .rec_dis_i(rdis), .ev_valid_i(ev_valid),
    .ev_pc_i(ev_pc), .ev_tgt_i(ev_tgt), .ev_type_i(ev_type), .rd_idx_i(rd_idx),
    .rd_data_o(rd_data), .wr_ofs_o(wr_ofs));

  br_hist_ring #(.ENTRIES_LOG2(7)) i_br_hist_ring_clamp (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_upd_i(ctrl_upd), .mon_en_i(mon_en),
    .filt_mode_i(mode), .frz_sel_i(fsel), .frz_prob_i(fprob), .hyp_i(hv),
    .prob_i(pr), .new_arch_i(narch), .rec_dis_i(rdis), .ev_valid_i(ev_valid),
    .ev_pc_i(ev_pc), .ev_tgt_i(ev_tgt), .ev_type_i(ev_type), .rd_idx_i(rd_idx),
    .rd_data_o(rd_data_c), .wr_ofs_o(wr_ofs_c));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic verify_all(input string req);
    chk(req, 64'(wr_ofs), 64'(exp_ofs));
    for (int i = 0; i < N; i++) begin
      rd_idx = 5'(i);
      #1;
      chk(req, rd_data, exp_mem[i]);
    end
  endtask

  task automatic set_ctrl(input logic en, input logic [1:0] m);
    @(negedge clk);
    ctrl_upd = 1; mon_en = en; mode = m;
    @(negedge clk);
    ctrl_upd = 0;
  endtask

  task automatic send(input logic [63:0] pc, input logic [63:0] tgt,
                      input logic [4:0] typ, input bit rec, input string req);
    @(negedge clk);
    ev_valid = 1; ev_pc = pc; ev_tgt = tgt; ev_type = typ;
    @(negedge clk);
    ev_valid = 0;
    if (rec) begin
      exp_mem[exp_ofs] = pc;
      exp_ofs = (exp_ofs + 1) % N;
      if (typ[4]) begin
        exp_mem[exp_ofs] = tgt | 64'h2;
        exp_ofs = (exp_ofs + 1) % N;
      end
    end
    chk(req, 64'(wr_ofs), 64'(exp_ofs));
  endtask

  task automatic t_reset;
    for (int i = 0; i < N; i++) exp_mem[i] = '0;
    exp_ofs = 0;
    send(64'h1000, 64'h0, 5'h01, 0, "R1 no record before control load");
    send(64'h1004, 64'h0, 5'h08, 0, "R1 no record before control load");
    verify_all("R1 reset state");
  endtask

  task automatic t_all_mode;
    set_ctrl(1, 2'd0);
    send(64'h2000, 64'h0, 5'h01, 1, "R7 mode0 call");
    send(64'h2010, 64'h0, 5'h08, 1, "R2 mode0 other");
    send(64'h2020, 64'h0, 5'h00, 0, "R2 type zero");
    send(64'h2030, 64'h0, 5'h04, 1, "R2 mode0 cond");
    verify_all("R7 R9 sequential entries");
  endtask

  task automatic t_mode_filters;
    set_ctrl(1, 2'd1);
    send(64'h3000, 64'h0, 5'h02, 0, "R2 mode1 rejects indirect");
    send(64'h3004, 64'h0, 5'h01, 1, "R2 mode1 call");
    send(64'h3008, 64'h0, 5'h04, 0, "R2 mode1 rejects cond");
    set_ctrl(1, 2'd2);
    send(64'h3010, 64'h0, 5'h02, 1, "R2 mode2 indirect");
    send(64'h3014, 64'h0, 5'h01, 0, "R2 mode2 rejects call");
    set_ctrl(1, 2'd3);
    send(64'h3020, 64'h0, 5'h04, 1, "R2 mode3 cond");
    send(64'h3024, 64'h0, 5'h08, 0, "R2 mode3 rejects other");
    verify_all("R2 filter modes");
  endtask

  task automatic t_alert;
    set_ctrl(0, 2'd0);
    send(64'h4000, 64'h0, 5'h01, 0, "R3 alert off blocks call");
    send(64'h4004, 64'h0, 5'h1F, 0, "R3 alert off blocks all");
    verify_all("R3 alert off");
  endtask

  task automatic t_ctrl_timing;
    set_ctrl(1, 2'd1);
    @(negedge clk);
    ctrl_upd = 1; mode = 2'd2;
    ev_valid = 1; ev_pc = 64'h5000; ev_type = 5'h02;
    @(negedge clk);
    ctrl_upd = 0; ev_valid = 0;
    chk("R4 same-cycle load uses old filter", 64'(wr_ofs), 64'(exp_ofs));
    send(64'h5004, 64'h0, 5'h02, 1, "R4 new filter next cycle");
    verify_all("R4 control timing");
  endtask

  task automatic t_freeze;
    set_ctrl(1, 2'd0);
    pr = 1;
    fsel = 1; fprob = 1; hv = 1;
    send(64'h6000, 64'h0, 5'h01, 0, "R5 S1 P1 H1 Q1 blocked");
    hv = 0;
    send(64'h6004, 64'h0, 5'h01, 1, "R5 S1 P1 H0 Q1 recorded");
    fprob = 0; hv = 0;
    send(64'h6008, 64'h0, 5'h01, 0, "R5 S1 P0 H0 Q1 blocked");
    hv = 1;
    send(64'h600C, 64'h0, 5'h01, 1, "R5 S1 P0 H1 Q1 recorded");
    fsel = 0; fprob = 1; hv = 0;
    send(64'h6010, 64'h0, 5'h01, 0, "R5 S0 P1 Q1 blocked");
    pr = 0;
    send(64'h6014, 64'h0, 5'h01, 1, "R5 S0 P1 Q0 recorded");
    fprob = 0; pr = 1;
    send(64'h6018, 64'h0, 5'h01, 1, "R5 S0 P0 recorded");
    verify_all("R5 freeze rules");
  endtask

  task automatic t_new_arch;
    narch = 1; pr = 0; rdis = 0;
    send(64'h7000, 64'h0, 5'h01, 0, "R6 newer mode not problem state");
    pr = 1; rdis = 1;
    send(64'h7004, 64'h0, 5'h01, 0, "R6 newer mode disable bit");
    rdis = 0;
    send(64'h7008, 64'h0, 5'h01, 1, "R6 newer mode allowed");
    narch = 0; pr = 0;
    send(64'h700C, 64'h0, 5'h01, 1, "R6 older mode ignores PR=0");
    pr = 1;
    verify_all("R6 newer mode");
  endtask

  task automatic t_xl;
    send(64'h8000, 64'hABCD_0000, 5'h12, 1, "R8 register-target indirect");
    send(64'h8010, 64'hABCD_0101, 5'h11, 1, "R8 register-target call keeps set bits");
    verify_all("R8 target entries");
  endtask

  task automatic t_wrap;
    int k = 0;
    while (exp_ofs != N - 1) begin
      send(64'h9000 + 64'(k * 4), 64'h0, 5'h08, 1, "R7 fill");
      k++;
    end
    send(64'h9F00, 64'h1234_5670, 5'h12, 1, "R8 second write wraps to 0");
    verify_all("R8 wrap");
    chk("R10 clamped instance offset", 64'(wr_ofs_c), 64'(exp_ofs));
    rd_idx = 5'd0;
    #1;
    chk("R10 clamped instance wrap entry", rd_data_c, 64'h1234_5672);
  endtask

  task automatic t_reset_again;
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < N; i++) exp_mem[i] = '0;
    exp_ofs = 0;
    verify_all("R1 reset clears written store");
    send(64'hA000, 64'h0, 5'h01, 0, "R1 filter reset to record nothing");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_all_mode();
    t_mode_filters();
    t_alert();
    t_ctrl_timing();
    t_freeze();
    t_new_arch();
    t_xl();
    t_wrap();
    t_reset_again();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule